// File: doc/BRIEF.md
# Microcode Parity Error and Interrupt Latch

This block holds two status flags for a microcoded processor. The first is a sticky control-store parity error. Each microinstruction arrives with a group of parity bits, and these bits are sampled on the same edge that loads the microinstruction register. If the group has odd parity, the flag is set at the end of the cycle that used the faulty word. The second flag is a software interrupt. Microcode sets it by pulling an active-low request input low.

One active-low clear input serves both flags, but its priority differs between them. For the error flag, a new parity error in the same cycle beats the clear. For the interrupt flag, the clear beats a set request.

While the machine is held in a wait or suspended state, neither flag changes. Parity errors seen during those cycles are dropped and never reported. Both outputs come straight from registers.

Top module: `ucode_parity_irq_latch`

## Requirements
- R1: With hold low and clear high, an odd number of ones across the six parity inputs sets `par_err` at the next rising edge. All six inputs take part equally, including the two that a reduced build ties low.
- R2: Once `par_err` is 1, it stays 1 while `clr_n` is high, whatever parity arrives.
- R3: With hold low, `clr_n` low and even parity, `par_err` is 0 after the next rising edge.
- R4: With hold low, `clr_n` low and odd parity in the same cycle, `par_err` is 1 after the next rising edge, so the clear has no effect.
- R5: With hold low and `clr_n` high, `irq_req_n` low sets `irq_flag` at the next rising edge.
- R6: With hold low and `clr_n` low, `irq_flag` is 0 after the next rising edge, even if `irq_req_n` is low.
- R7: With hold low, `clr_n` high and `irq_req_n` high, `irq_flag` keeps its value.
- R8: While `hold` is high, neither flag changes. A parity error, request or clear presented during that cycle is dropped.
- R9: A synchronous active-high `rst` drives both flags to 0 at the next rising edge, and it overrides every other input.
- R10: Both outputs change only at a rising clock edge. A change on any input between edges does not reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Machine waiting or suspended; freezes both flags |
| par_bits | input | PAR_W (6) | Parity bits captured with the current microinstruction |
| irq_req_n | input | 1 | Interrupt set request, active low |
| clr_n | input | 1 | Shared flag clear, active low |
| par_err | output | 1 | Sticky control-store parity error flag |
| irq_flag | output | 1 | Software interrupt flag |

## Verification
The bench aims at the cycle where `clr_n` and an odd parity group arrive together. A design that let the clear win there would silently lose an error. It also drives `clr_n` together with a low `irq_req_n`; a design with the priority backwards would leave a spurious interrupt set.

Single-bit parity patterns go through every input, including the two that may be tied low. A reduction that skipped those two would miss errors on them. Hold cycles carry odd parity, requests and clears, so a design that updated a flag while suspended would report or clear a flag it should have frozen. A long random run then compares both flags against the reference model on every cycle.

// File: rtl/ucode_parity_irq_latch.sv
module ucode_parity_irq_latch #(
  parameter int PAR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [PAR_W-1:0] par_bits,
  input  logic             irq_req_n,
  input  logic             clr_n,
  output logic             par_err,
  output logic             irq_flag
);

  logic bad_word;
  logic err_next;
  logic irq_next;

  assign bad_word = ^par_bits;
  assign err_next = (!clr_n && !bad_word) ? 1'b0 : (bad_word | par_err);
  assign irq_next = !clr_n ? 1'b0 : (irq_flag | !irq_req_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      par_err  <= 1'b0;
      irq_flag <= 1'b0;
    end else if (!hold) begin
      par_err  <= err_next;
      irq_flag <= irq_next;
    end
  end

endmodule

// File: rtl/ucode_parity_irq_latch_chk.sv
module ucode_parity_irq_latch_chk #(
  parameter int PAR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic [PAR_W-1:0] par_bits,
  input logic             irq_req_n,
  input logic             clr_n,
  input logic             par_err,
  input logic             irq_flag
);

  // R1
  odd_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && clr_n && ($countones(par_bits) % 2 == 1)) |=> par_err);

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && clr_n && par_err) |=> par_err);

  // R3
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr_n && ($countones(par_bits) % 2 == 0)) |=> !par_err);

  // R4
  err_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr_n && ($countones(par_bits) % 2 == 1)) |=> par_err);

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && clr_n && !irq_req_n) |=> irq_flag);

  // R6
  irq_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr_n) |=> !irq_flag);

  // R7
  irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && clr_n && irq_req_n) |=> (irq_flag == $past(irq_flag)));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(par_err) && $stable(irq_flag)));

endmodule

bind ucode_parity_irq_latch ucode_parity_irq_latch_chk #(.PAR_W(PAR_W)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .par_bits(par_bits),
  .irq_req_n(irq_req_n), .clr_n(clr_n), .par_err(par_err), .irq_flag(irq_flag)
);

// File: tb/ucode_parity_irq_latch_tb.sv
`timescale 1ns/1ps
module ucode_parity_irq_latch_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic [5:0] par_bits = '0;
  logic       irq_req_n = 1'b1;
  logic       clr_n = 1'b1;
  logic       par_err;
  logic       irq_flag;

  int  checks = 0;
  int  failures = 0;
  bit  err_m = 0;
  bit  irq_m = 0;
  bit  primed = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  ucode_parity_irq_latch u_dut (
    .clk(clk), .rst(rst), .hold(hold), .par_bits(par_bits),
    .irq_req_n(irq_req_n), .clr_n(clr_n), .par_err(par_err), .irq_flag(irq_flag)
  );

  task automatic check(string tag, string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit h, logic [5:0] p, bit rq_n, bit cl_n);
    string et, it;
    int ones;
    bit odd;
    rst = r; hold = h; par_bits = p; irq_req_n = rq_n; clr_n = cl_n;
    #1;
    if (primed) begin
      check("R10", "par_err mid-cycle", par_err, err_m);
      check("R10", "irq_flag mid-cycle", irq_flag, irq_m);
    end
    ones = 0;
    for (int i = 0; i < 6; i++) ones += p[i];
    odd = (ones % 2) == 1;
    if (r) begin
      et = "R9"; it = "R9"; err_m = 0; irq_m = 0;
    end else if (h) begin
      et = "R8"; it = "R8";
    end else begin
      if (!cl_n) begin
        et = odd ? "R4" : "R3";
        err_m = odd;
        it = "R6";
        irq_m = 0;
      end else begin
        et = odd ? "R1" : "R2";
        if (odd) err_m = 1;
        if (!rq_n) begin it = "R5"; irq_m = 1; end
        else it = "R7";
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(et, "par_err", par_err, err_m);
    check(it, "irq_flag", irq_flag, irq_m);
    primed = 1;
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 6'h00, 1, 1);                // R9 reset state
    step(0, 0, 6'h00, 1, 1);                // R7 idle
    for (int b = 0; b < 6; b++) begin       // R1 each bit alone, R3 clear
      step(0, 0, 6'(1 << b), 1, 1);
      step(0, 0, 6'h00, 1, 1);              // R2 sticky
      step(0, 0, 6'h00, 1, 0);              // R3
    end
    step(0, 0, 6'h30, 1, 1);                // R1 two tied bits: even, no error
    step(0, 0, 6'h3F, 1, 1);                // even, no error
    step(0, 0, 6'h07, 1, 1);                // R1 odd
    step(0, 0, 6'h00, 1, 0);                // R3
    step(0, 0, 6'h10, 1, 0);                // R4 clear with new error
    step(0, 0, 6'h00, 0, 1);                // R5 set irq
    step(0, 0, 6'h00, 1, 1);                // R7 keep
    step(0, 0, 6'h00, 0, 0);                // R6 clear beats request
    step(0, 0, 6'h00, 0, 1);                // R5
    step(0, 1, 6'h00, 1, 0);                // R8 clear dropped
    step(0, 1, 6'h20, 1, 1);                // R8
    step(0, 0, 6'h00, 1, 0);                // R3 err and irq clear
    step(0, 1, 6'h01, 0, 1);                // R8 error and request dropped
    step(0, 0, 6'h00, 1, 1);                // R7
    step(0, 0, 6'h21, 0, 1);
    step(1, 0, 6'h01, 0, 1);                // R9 reset overrides
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 64) == 0, ($urandom % 4) == 0, 6'($urandom),
           ($urandom % 3) != 0, ($urandom % 5) != 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule